// File: doc/BRIEF.md
# Cursor Overlay Pixel Mux

This block is a streaming stage in a display pipeline. It sits after the frame-memory fetch and before the video output. Each cycle it can accept one pixel. A pixel arrives as its screen coordinates and an 8-bit palette index. The stage decides whether the pixel falls inside a 64×64 hardware cursor window. Inside the window it reads a 2-bit cursor code from a pattern store. The code selects either the pixel's own palette colour or one of three fixed cursor colours. The result is a 24-bit RGB value.

The block does not hold the colour palette or the cursor pattern. It drives read addresses into both stores and expects each store to return data one clock after the address is presented. The control word, the cursor position word and the three cursor colours are quasi-static configuration inputs. The control word and the position word are sampled together with each pixel. Two control bits act on the stream. One hides the cursor. The other forces the whole output to black.

Top module: `cursor_overlay_mux`

## Requirements
- R1: The cursor position word is split so that cursor X is `cursor_pos[23:12]` and cursor Y is `cursor_pos[11:0]`.
- R2: A pixel is inside the cursor window exactly when cy ≤ y < cy+64 and cx ≤ x < cx+64. The bounds are evaluated with one extra bit, so a cursor placed near coordinate 4095 never wraps around to cover pixels at small coordinates.
- R3: For a pixel inside the window, `pat_rd_addr` becomes (y−cy)·8 + (x−cx)/8 one clock after the pixel is sampled. The pixel's code is bits [2k+1:2k] of the returned 16-bit word, with k = (x−cx) mod 8.
- R4: `pal_rd_addr` carries the pixel index. When the pixel is outside the window, or its code is 0, the output equals the 24-bit palette word returned for that index.
- R5: A code n in the range 1 to 3 outputs cursor colour n−1. Cursor colour n−1 occupies bits [24(n−1)+23 : 24(n−1)] of `cur_colors`.
- R6: When bit 23 of `ctrl_word` is set, the cursor is never drawn and every pixel shows its palette colour.
- R7: When bit 10 of `ctrl_word` is set, every output pixel is 24'h000000. This bit takes precedence over everything else.
- R8: `out_valid` asserts exactly two clocks after the edge that samples `in_valid`. Results come out in input order, and a continuous stream is accepted at one pixel per clock.
- R9: While reset is asserted, `out_valid` is 0 and `out_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel on the inputs is valid this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Palette index of the pixel |
| ctrl_word | input | 32 | Control word (bit 23 hides the cursor, bit 10 forces black) |
| cursor_pos | input | 24 | Packed cursor position {X, Y} |
| cur_colors | input | 72 | Three packed 24-bit cursor colours |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette read data, one clock after the address |
| pat_rd_addr | output | 9 | Cursor pattern read address |
| pat_rd_data | input | 16 | Pattern word, one clock after the address |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output colour {R, G, B} |

## Verification
The bench sweeps pixels one column and one row outside each edge of the window. A design with an off-by-one bound would show the cursor on a palette pixel there, or the palette colour on a cursor pixel. It places the cursor at (4090, 4090) and probes pixels at small coordinates. A 12-bit comparison would wrap and paint cursor codes onto those pixels. It streams a row through the window with no gaps, which catches a wrong word or sub-pixel pick and any stage that drops or reorders pixels. It also sets each control bit separately, and both together, to expose a missing precedence of blanking over the cursor.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
   // Bits per cursor pixel; one code selects the underlying colour.
   localparam int CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      CODE_SHOW_BASE = 2'd0,
      CODE_COLOUR_A  = 2'd1,
      CODE_COLOUR_B  = 2'd2,
      CODE_COLOUR_C  = 2'd3
   } cur_code_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cursor_window.sv
// Window test and pattern addressing for one pixel (combinational).
module cursor_window #(
   parameter int COORD_W = 12,
   parameter int CUR_DIM = 64,
   parameter int PPW     = 8,
   localparam int EXT_W  = COORD_W + 1,
   localparam int DIM_W  = $clog2(CUR_DIM),
   localparam int SUB_W  = $clog2(PPW),
   localparam int PAT_AW = 2 * DIM_W - SUB_W
) (
   input  logic [COORD_W-1:0] px,
   input  logic [COORD_W-1:0] py,
   input  logic [COORD_W-1:0] cx,
   input  logic [COORD_W-1:0] cy,
   input  logic               cursor_en,
   output logic               hit,
   output logic [PAT_AW-1:0]  pat_addr,
   output logic [SUB_W-1:0]   sub
);
   logic [EXT_W-1:0] dx, dy;
   logic             in_x, in_y;

   // One extra bit: pixel - corner never wraps to a small value (R2).
   always_comb begin
      dx   = {1'b0, px} - {1'b0, cx};
      dy   = {1'b0, py} - {1'b0, cy};
      in_x = ({1'b0, px} >= {1'b0, cx}) && (dx < EXT_W'(CUR_DIM));
      in_y = ({1'b0, py} >= {1'b0, cy}) && (dy < EXT_W'(CUR_DIM));
      hit  = cursor_en && in_x && in_y;
   end

   // Row-major word index: row offset times words per row plus word in row (R3).
   assign pat_addr = {dy[DIM_W-1:0], dx[DIM_W-1:SUB_W]};
   assign sub      = dx[SUB_W-1:0];
endmodule

// File: rtl/overlay_select.sv
// Code extraction and colour choice (combinational).
module overlay_select
   import cursor_overlay_pkg::*;
#(
   parameter int CHAN_W     = 8,
   parameter int PAT_WORD_W = 16,
   localparam int RGB_W     = 3 * CHAN_W,
   localparam int PPW       = PAT_WORD_W / CODE_W,
   localparam int SUB_W     = $clog2(PPW),
   localparam int NUM_SEL   = 2 ** CODE_W,
   localparam int NUM_CUR   = NUM_SEL - 1
) (
   input  logic                     hit,
   input  logic [SUB_W-1:0]         sub,
   input  logic [PAT_WORD_W-1:0]    pat_word,
   input  logic [RGB_W-1:0]         base_rgb,
   input  logic [NUM_CUR*RGB_W-1:0] cur_colors,
   input  logic                     blank,
   output logic [CODE_W-1:0]        code,
   output logic [RGB_W-1:0]         rgb
);
   logic [RGB_W-1:0] choice [NUM_SEL];

   // Slot 0 is the pixel's own colour; slots 1..3 are the cursor colours.
   assign choice[0] = base_rgb;
   for (genvar g = 1; g < NUM_SEL; g++) begin : g_cur_slot
      assign choice[g] = cur_colors[(g-1)*RGB_W +: RGB_W];
   end

   always_comb begin
      code = hit ? pat_word[{sub, 1'b0} +: CODE_W] : CODE_W'(CODE_SHOW_BASE);
      rgb  = blank ? '0 : choice[code];
   end
endmodule

// File: rtl/cursor_overlay_mux.sv
module cursor_overlay_mux
   import cursor_overlay_pkg::*;
#(
   parameter int COORD_W    = 12,
   parameter int IDX_W      = 8,
   parameter int CHAN_W     = 8,
   parameter int CUR_DIM    = 64,
   parameter int PAT_WORD_W = 16,
   parameter int CTRL_W     = 32,
   parameter int NOCUR_BIT  = 23,
   parameter int BLANK_BIT  = 10,
   localparam int RGB_W     = 3 * CHAN_W,
   localparam int POS_W     = 2 * COORD_W,
   localparam int PPW       = PAT_WORD_W / CODE_W,
   localparam int DIM_W     = $clog2(CUR_DIM),
   localparam int SUB_W     = $clog2(PPW),
   localparam int PAT_AW    = 2 * DIM_W - SUB_W,
   localparam int NUM_CUR   = (2 ** CODE_W) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [COORD_W-1:0]       in_x,
   input  logic [COORD_W-1:0]       in_y,
   input  logic [IDX_W-1:0]         in_index,
   input  logic [CTRL_W-1:0]        ctrl_word,
   input  logic [POS_W-1:0]         cursor_pos,
   input  logic [NUM_CUR*RGB_W-1:0] cur_colors,
   output logic [IDX_W-1:0]         pal_rd_addr,
   input  logic [RGB_W-1:0]         pal_rd_data,
   output logic [PAT_AW-1:0]        pat_rd_addr,
   input  logic [PAT_WORD_W-1:0]    pat_rd_data,
   output logic                     out_valid,
   output logic [RGB_W-1:0]         out_rgb
);
   // Elaboration-time parameter checks.
   initial begin
      assert (is_pow2(CUR_DIM)) else $error("CUR_DIM must be a power of two");
      assert (PAT_WORD_W % CODE_W == 0 && is_pow2(PPW))
         else $error("pattern word must hold a power-of-two pixel count");
      assert (CUR_DIM % PPW == 0) else $error("cursor row must be whole words");
      assert (NOCUR_BIT < CTRL_W && BLANK_BIT < CTRL_W && NOCUR_BIT != BLANK_BIT)
         else $error("control bit positions out of range");
      assert ((2 ** COORD_W) > CUR_DIM) else $error("coordinate too narrow");
   end

   // Position word unpack (R1).
   logic [COORD_W-1:0] cur_x, cur_y;
   assign cur_x = cursor_pos[POS_W-1:COORD_W];
   assign cur_y = cursor_pos[COORD_W-1:0];

   logic              w_hit;
   logic [PAT_AW-1:0] w_addr;
   logic [SUB_W-1:0]  w_sub;

   cursor_window #(
      .COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .PPW(PPW)
   ) u_window (
      .px(in_x), .py(in_y), .cx(cur_x), .cy(cur_y),
      .cursor_en(!ctrl_word[NOCUR_BIT]),
      .hit(w_hit), .pat_addr(w_addr), .sub(w_sub)
   );

   // Stage 1: addresses go out to the stores.
   logic             s1_valid, s1_hit, s1_blank;
   logic [SUB_W-1:0] s1_sub;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid    <= 1'b0;
         s1_hit      <= 1'b0;
         s1_blank    <= 1'b0;
         s1_sub      <= '0;
         pal_rd_addr <= '0;
         pat_rd_addr <= '0;
      end else begin
         s1_valid    <= in_valid;
         s1_hit      <= w_hit;
         s1_blank    <= ctrl_word[BLANK_BIT];
         s1_sub      <= w_sub;
         pal_rd_addr <= in_index;
         pat_rd_addr <= w_addr;
      end
   end

   // Stage 2: store data arrives; the side-band is delayed to match.
   logic             s2_valid, s2_hit, s2_blank;
   logic [SUB_W-1:0] s2_sub;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_hit   <= 1'b0;
         s2_blank <= 1'b0;
         s2_sub   <= '0;
      end else begin
         s2_valid <= s1_valid;
         s2_hit   <= s1_hit;
         s2_blank <= s1_blank;
         s2_sub   <= s1_sub;
      end
   end

   logic [CODE_W-1:0] sel_code;
   logic [RGB_W-1:0]  sel_rgb;

   overlay_select #(
      .CHAN_W(CHAN_W), .PAT_WORD_W(PAT_WORD_W)
   ) u_select (
      .hit(s2_hit), .sub(s2_sub), .pat_word(pat_rd_data),
      .base_rgb(pal_rd_data), .cur_colors(cur_colors), .blank(s2_blank),
      .code(sel_code), .rgb(sel_rgb)
   );

   // Output register (R8, R9).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= s2_valid;
         out_rgb   <= sel_rgb;
      end
   end

   // ---------------- assertions ----------------
   logic [RGB_W-1:0] cur_pick;
   always_comb begin
      cur_pick = '0;
      for (int n = 1; n <= NUM_CUR; n++)
         if (int'(sel_code) == n) cur_pick = cur_colors[(n-1)*RGB_W +: RGB_W];
   end

   p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_blank) |=> (out_valid && out_rgb == '0));

   p_base_colour_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_blank && sel_code == '0) |=> (out_rgb == $past(pal_rd_data)));

   p_cursor_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_blank && sel_code != '0) |=> (out_rgb == $past(cur_pick)));

   p_hidden_cursor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl_word[NOCUR_BIT]) |=> !s1_hit);

   p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(s2_valid));
endmodule

// File: tb/cursor_overlay_mux_tb.sv
module cursor_overlay_mux_tb_top;
   localparam int RGB_W = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_x = '0, in_y = '0;
   logic [7:0]  in_index = '0;
   logic [31:0] ctrl_word = '0;
   logic [23:0] cursor_pos = '0;
   logic [71:0] cur_colors = {24'hC0FFEE, 24'h00A5A5, 24'hFF0000};
   logic [7:0]  pal_rd_addr;
   logic [23:0] pal_rd_data;
   logic [8:0]  pat_rd_addr;
   logic [15:0] pat_rd_data;
   logic        out_valid;
   logic [23:0] out_rgb;

   always #4 clk = ~clk; // 125 MHz

   cursor_overlay_mux dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
      .in_index(in_index), .ctrl_word(ctrl_word), .cursor_pos(cursor_pos),
      .cur_colors(cur_colors), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
      .pat_rd_addr(pat_rd_addr), .pat_rd_data(pat_rd_data),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   // Synchronous-read stores owned by the bench.
   logic [23:0] pal_mem [256];
   logic [15:0] pat_mem [512];
   initial begin
      for (int i = 0; i < 256; i++) pal_mem[i] = {8'(i), 8'(255 - i), 8'(i * 3)};
      for (int i = 0; i < 512; i++) pat_mem[i] = 16'(i * 16'h9E37 + 16'h1234);
   end
   always @(posedge clk) begin
      pal_rd_data <= pal_mem[pal_rd_addr];
      pat_rd_data <= pat_mem[pat_rd_addr];
   end

   int tests = 0, fails = 0;

   typedef struct {
      logic [23:0] rgb;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   // Reference colour from the requirements.
   function automatic logic [23:0] model(int x, int y, int idx);
      int cx, cy, w, k, code;
      if (ctrl_word[10]) return 24'h0;                         // R7
      cx = int'(cursor_pos[23:12]);                            // R1
      cy = int'(cursor_pos[11:0]);
      if (!ctrl_word[23] && x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin // R2, R6
         w    = (y - cy) * 8 + (x - cx) / 8;                   // R3
         k    = (x - cx) % 8;
         code = int'((pat_mem[w] >> (2 * k)) & 16'h3);
         if (code != 0) return cur_colors[(code - 1) * 24 +: 24]; // R5
      end
      return pal_mem[idx];                                     // R4
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Driver: called at a falling edge; leaves at the next falling edge.
   task automatic drive_px(int x, int y, int idx, string tag);
      exp_t e;
      in_valid = 1'b1;
      in_x     = 12'(x);
      in_y     = 12'(y);
      in_index = 8'(idx);
      e.rgb    = model(x, y, idx);
      e.tag    = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: compares each produced pixel against the queue head (R8 order).
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R8 unexpected output", 32'(out_rgb), 32'hFFFFFFFF);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, 32'(out_rgb), 32'(e.rgb));
         end
      end
   end

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R9 reset out_valid", 32'(out_valid), 32'h0);
      check("R9 reset out_rgb", 32'(out_rgb), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Cursor at (100, 50): X in the upper field, Y in the lower (R1).
      cursor_pos = {12'd100, 12'd50};
      drive_px(99, 50, 7, "R2 left of window");
      drive_px(100, 49, 8, "R2 above window");
      drive_px(100, 50, 9, "R2 top-left corner");
      drive_px(163, 113, 10, "R2 bottom-right corner");
      drive_px(164, 60, 11, "R2 right of window");
      drive_px(110, 114, 12, "R2 below window");
      drive_px(50, 100, 13, "R1 swapped position outside");
      idle(1);
      // Pattern address: (5*8 + 19/8) = 42 (R3).
      drive_px(119, 55, 20, "R3 pixel colour");
      check("R3 pattern address", 32'(pat_rd_addr), 32'd42);
      idle(4);

      // Continuous row through the window (R3, R5, R8).
      for (int x = 96; x < 172; x++) drive_px(x, 60, x & 255, "R5 streamed row");
      for (int y = 48; y < 118; y++) drive_px(130, y, y, "R3 streamed column");
      idle(4);

      // Edge placement: no wrap to small coordinates (R2).
      cursor_pos = {12'd4090, 12'd4090};
      drive_px(5, 5, 30, "R2 no wrap small xy");
      drive_px(5, 4092, 31, "R2 no wrap small x");
      drive_px(4095, 4095, 32, "R2 edge inside");
      drive_px(4090, 4090, 33, "R2 edge corner");
      idle(4);

      // Cursor hidden (R6).
      cursor_pos = {12'd100, 12'd50};
      ctrl_word  = 32'h0080_0000;
      for (int x = 100; x < 116; x++) drive_px(x, 51, 40 + x, "R6 cursor hidden");
      idle(4);

      // Forced black, with and without cursor hiding (R7).
      ctrl_word = 32'h0000_0400;
      drive_px(100, 50, 50, "R7 blank inside");
      drive_px(10, 10, 51, "R7 blank outside");
      ctrl_word = 32'h0080_0400;
      drive_px(120, 60, 52, "R7 blank both bits");
      idle(4);
      ctrl_word = 32'h0;
      drive_px(10, 10, 0, "R4 base colour after blank");
      idle(6);

      check("R8 all outputs delivered", 32'(exp_q.size()), 32'd0);
      finish_run();
   end
endmodule